// File: doc/BRIEF.md
# Serial PRBS and Fixed-Pattern Checker with Sync Tracking

This block checks a serial bit stream against one of eight maximal-length pseudo-random sequences or eight repeating 8-bit words. On each enabled clock it takes one received bit and predicts the bit it should have been. In sequence modes the prediction comes from an LFSR that loads itself from the incoming bits until lock. In word modes it comes from a phase pointer that slides along the word until the stream lines up.

Lock is declared after a mode-dependent run of matching bits. Lock is dropped when a 128-bit sliding window holds too many errors, and a one-bit-period pulse marks the drop. Single bit errors are reported 128 bits late, and only if lock survives that long, so a burst that breaks lock never shows up as individual errors. A clock-slip flag is provided but always reads low.

Top module: `prbs_rx_sync`

## Requirements
- R1: Mode codes 0 to 7 select sequences of register length L with recurrence b[n] = b[n-a] ^ b[n-L], as (code: a, L): 0: 5,9; 1: 9,11; 2: 14,15; 3: 17,20; 4: 3,20; 5: 18,23; 6: 27,29; 7: 28,31. Codes 8 to 15 select repeating words, sent MSB first, of hex 00, FF, 55, 33, 7F, 80, 77, 88 in code order.
- R2: A high cfg_load_i on any clock edge latches cfg_type_i and cfg_inv_i, regardless of en_i. It clears lock, the run counter, the error window and the word phase, and sets the predictor to all ones. After that edge sync_o, sync_lost_o and bit_err_o are low, and no loss pulse is produced.
- R3: With the invert flag latched and a sequence mode selected, the received bit is complemented before comparison and seeding. In word modes the flag has no effect.
- R4: In sequence modes the predicted bit is h[a] ^ h[L], where h[k] is the k-th most recent bit shifted into the predictor. While unlocked the received bit (after R3) is shifted in. While locked the prediction itself is shifted in. sync_o rises on the enabled edge that completes 2*L consecutive matches.
- R5: In word modes the expected bit is word bit (7 - phase). The phase is 0 after reset or load and advances by one each enabled clock, or by two after a mismatch while unlocked. sync_o rises on the enabled edge that completes 20 consecutive matches.
- R6: While locked, the checker counts errors over the last 128 enabled bits. Lock drops on the enabled edge where that count would exceed 25. Exactly 25 errors keep lock.
- R7: sync_lost_o is high for exactly one enabled bit period, starting at the edge where lock drops.
- R8: An error on a bit received while locked sets bit_err_o for one enabled bit period, 128 enabled clocks later, but only if lock held throughout. Errors still inside the window when lock drops are never reported. bit_err_o is high only while sync_o is high.
- R9: clk_err_o is always low.
- R10: Reset is asynchronous and active low. It selects mode 0 with no inversion, sets the predictor to all ones and drives all outputs low. With en_i low and no load, no state or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bit enable; one received bit per high cycle |
| cfg_load_i | input | 1 | Latch mode and invert flag, restart acquisition |
| cfg_type_i | input | 4 | Mode code (R1) |
| cfg_inv_i | input | 1 | Sequence polarity invert |
| rx_bit_i | input | 1 | Received serial bit |
| sync_o | output | 1 | Locked to the stream |
| sync_lost_o | output | 1 | One-bit-period pulse on loss of lock |
| bit_err_o | output | 1 | Delayed single-bit error flag |
| clk_err_o | output | 1 | Bit-slip flag, constant low |

## Verification
The bench aims at the window threshold from both sides. 25 spaced errors must keep lock and all be reported 128 bits later. A 26th error must drop lock at once and suppress every pending report; a design that counts the boundary wrongly, or drains its delay line after loss, shows up as a missing pulse or an extra error pulse. It also reloads the mode mid-lock, where a design that treats the reload as a loss would emit a spurious loss pulse. It feeds a sequence of the wrong polarity, where a design that applies the invert flag in the wrong place would still lock. Word modes start at odd phase offsets, so an aligner that steps wrongly would never lock. Enable gaps show whether any state moves on idle cycles.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;
  localparam int unsigned LFSR_W = 31;
  localparam int unsigned PAT_W  = 8;

  function automatic int unsigned seq_len(input logic [2:0] sel);
    case (sel)
      3'd0: return 9;
      3'd1: return 11;
      3'd2: return 15;
      3'd3: return 20;
      3'd4: return 20;
      3'd5: return 23;
      3'd6: return 29;
      default: return 31;
    endcase
  endfunction

  function automatic int unsigned seq_tap(input logic [2:0] sel);
    case (sel)
      3'd0: return 5;
      3'd1: return 9;
      3'd2: return 14;
      3'd3: return 17;
      3'd4: return 3;
      3'd5: return 18;
      3'd6: return 27;
      default: return 28;
    endcase
  endfunction

  function automatic logic [PAT_W-1:0] pat_word(input logic [2:0] sel);
    case (sel)
      3'd0: return 8'h00;
      3'd1: return 8'hFF;
      3'd2: return 8'h55;
      3'd3: return 8'h33;
      3'd4: return 8'h7F;
      3'd5: return 8'h80;
      3'd6: return 8'h77;
      default: return 8'h88;
    endcase
  endfunction
endpackage

// File: rtl/prbs_rx_predict.sv
module prbs_rx_predict
  import prbs_rx_pkg::*;
#(
  parameter int unsigned LW = LFSR_W,
  parameter int unsigned PW = PAT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [3:0] mode_i,
  input  logic       sync_i,
  input  logic       rx_i,
  output logic       exp_o,
  output logic       miss_o
);
  localparam int unsigned IW  = $clog2(LW);
  localparam int unsigned PHW = $clog2(PW);

  logic [LW-1:0]  lfsr_q;
  logic [PHW-1:0] ph_q;
  logic [IW-1:0]  tap_idx, len_idx;
  logic [PHW-1:0] bit_idx;
  logic [PW-1:0]  word;
  logic           prbs_bit, pat_bit;

  always_comb begin
    tap_idx  = IW'(seq_tap(mode_i[2:0]) - 1);
    len_idx  = IW'(seq_len(mode_i[2:0]) - 1);
    word     = PW'(pat_word(mode_i[2:0]));
    bit_idx  = PHW'(PW - 1) - ph_q;
    prbs_bit = lfsr_q[tap_idx] ^ lfsr_q[len_idx];
    pat_bit  = word[bit_idx];
    exp_o    = mode_i[3] ? pat_bit : prbs_bit;
  end

  assign miss_o = rx_i ^ exp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '1;
      ph_q   <= '0;
    end else if (clr_i) begin
      lfsr_q <= '1;
      ph_q   <= '0;
    end else if (en_i) begin
      if (!mode_i[3]) lfsr_q <= {lfsr_q[LW-2:0], sync_i ? exp_o : rx_i};
      else            ph_q   <= ph_q + PHW'(1) + PHW'(miss_o & ~sync_i);
    end
  end

  AST_SEED_FROM_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !sync_i && !mode_i[3]) |=> lfsr_q[0] == $past(rx_i)); // R4
  AST_LOCKED_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && sync_i && mode_i[3]) |=> ph_q == PHW'($past(ph_q) + 1)); // R5
endmodule

// File: rtl/prbs_rx_window.sv
module prbs_rx_window #(
  parameter int unsigned WIN_LEN = 128,
  parameter int unsigned WIN_MAX = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic sync_i,
  input  logic err_i,
  output logic drop_o,
  output logic bit_err_o
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] hist_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic               oldest;

  always_comb begin
    oldest = hist_q[WIN_LEN-1];
    cnt_nx = cnt_q + CNT_W'(err_i) - CNT_W'(oldest);
    drop_o = en_i && !clr_i && sync_i && (cnt_nx > CNT_W'(WIN_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q    <= '0;
      cnt_q     <= '0;
      bit_err_o <= 1'b0;
    end else if (clr_i) begin
      hist_q    <= '0;
      cnt_q     <= '0;
      bit_err_o <= 1'b0;
    end else if (en_i) begin
      if (!sync_i || drop_o) begin
        // pending errors are discarded on loss
        hist_q    <= '0;
        cnt_q     <= '0;
        bit_err_o <= 1'b0;
      end else begin
        hist_q    <= {hist_q[WIN_LEN-2:0], err_i};
        cnt_q     <= cnt_nx;
        bit_err_o <= oldest;
      end
    end
  end

  AST_CNT_TRACKS_HIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == $countones(hist_q)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WIN_MAX)); // R6
  AST_BERR_ONLY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_err_o |-> sync_i); // R8
endmodule

// File: rtl/prbs_rx_sync.sv
module prbs_rx_sync
  import prbs_rx_pkg::*;
#(
  parameter int unsigned SEQ_W   = LFSR_W,
  parameter int unsigned WORD_W  = PAT_W,
  parameter int unsigned WIN_LEN = 128,
  parameter int unsigned WIN_MAX = 25,
  parameter int unsigned PAT_RUN = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cfg_load_i,
  input  logic [3:0] cfg_type_i,
  input  logic       cfg_inv_i,
  input  logic       rx_bit_i,
  output logic       sync_o,
  output logic       sync_lost_o,
  output logic       bit_err_o,
  output logic       clk_err_o
);
  localparam int unsigned RUN_W = $clog2(2 * SEQ_W + 1);

  logic [3:0]       mode_q;
  logic             inv_q, sync_q, lost_q;
  logic [RUN_W-1:0] run_q, target;
  logic             adv, rx_data, exp_bit, miss, drop;

  assign adv     = en_i && !cfg_load_i;
  assign rx_data = rx_bit_i ^ (inv_q & ~mode_q[3]);
  assign target  = mode_q[3] ? RUN_W'(PAT_RUN) : RUN_W'(2 * seq_len(mode_q[2:0]));

  prbs_rx_predict #(.LW(SEQ_W), .PW(WORD_W)) i_predict (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .clr_i  (cfg_load_i),
    .mode_i (mode_q),
    .sync_i (sync_q),
    .rx_i   (rx_data),
    .exp_o  (exp_bit),
    .miss_o (miss)
  );

  prbs_rx_window #(.WIN_LEN(WIN_LEN), .WIN_MAX(WIN_MAX)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (adv),
    .clr_i     (cfg_load_i),
    .sync_i    (sync_q),
    .err_i     (miss),
    .drop_o    (drop),
    .bit_err_o (bit_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      inv_q  <= 1'b0;
      sync_q <= 1'b0;
      lost_q <= 1'b0;
      run_q  <= '0;
    end else if (cfg_load_i) begin
      mode_q <= cfg_type_i;
      inv_q  <= cfg_inv_i;
      sync_q <= 1'b0;
      lost_q <= 1'b0;
      run_q  <= '0;
    end else if (en_i) begin
      if (!sync_q) begin
        lost_q <= 1'b0;
        if (miss) begin
          run_q <= '0;
        end else if (run_q + RUN_W'(1) == target) begin
          sync_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + RUN_W'(1);
        end
      end else if (drop) begin
        sync_q <= 1'b0;
        lost_q <= 1'b1;
      end else begin
        lost_q <= 1'b0;
      end
    end
  end

  assign sync_o      = sync_q;
  assign sync_lost_o = lost_q;
  assign clk_err_o   = 1'b0;

  AST_LOST_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sync_lost_o) |=> !sync_lost_o); // R7
  AST_LOST_MEANS_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_o |-> !sync_o); // R7
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (!sync_o && !sync_lost_o && !bit_err_o)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cfg_load_i) |=> ($stable(sync_o) && $stable(sync_lost_o) && $stable(bit_err_o))); // R10
endmodule

// File: tb/test_prbs_rx_sync.sv
`timescale 1ns/1ps
module test_prbs_rx_sync;
  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0, cfg_load_i = 1'b0, cfg_inv_i = 1'b0, rx_bit_i = 1'b0;
  logic [3:0] cfg_type_i = 4'd0;
  logic sync_o, sync_lost_o, bit_err_o, clk_err_o;

  always #5 clk = ~clk;

  prbs_rx_sync i_prbs_rx_sync (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cfg_load_i(cfg_load_i),
    .cfg_type_i(cfg_type_i), .cfg_inv_i(cfg_inv_i), .rx_bit_i(rx_bit_i),
    .sync_o(sync_o), .sync_lost_o(sync_lost_o), .bit_err_o(bit_err_o), .clk_err_o(clk_err_o)
  );

  int n_chk = 0, n_err = 0;
  int berr_cnt = 0, lost_cnt = 0;
  bit done = 1'b0;

  // reference model state
  int m_type = 0, m_ph = 0, m_run = 0;
  bit m_inv = 0, m_sync = 0, m_lost = 0, m_berr = 0;
  bit m_h[1:31];
  bit errq[$];

  // stimulus source
  int s_type = 0, g_pos = 0;
  bit g_h[1:31];

  function automatic int b_len(input int t);
    int l[8] = '{9, 11, 15, 20, 20, 23, 29, 31};
    return l[t % 8];
  endfunction
  function automatic int b_tap(input int t);
    int a[8] = '{5, 9, 14, 17, 3, 18, 27, 28};
    return a[t % 8];
  endfunction
  function automatic int b_word(input int t);
    int w[8] = '{'h00, 'hFF, 'h55, 'h33, 'h7F, 'h80, 'h77, 'h88};
    return w[t % 8];
  endfunction

  function automatic bit m_exp();
    if (m_type < 8) return m_h[b_tap(m_type)] ^ m_h[b_len(m_type)];
    return bit'((b_word(m_type) >> (7 - m_ph)) & 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit rx, input bit en, input bit ld);
    bit rd, e, er, d;
    int s;
    if (ld) begin
      m_type = int'(cfg_type_i); m_inv = cfg_inv_i;
      m_sync = 0; m_run = 0; m_ph = 0; m_lost = 0; m_berr = 0;
      for (int k = 1; k <= 31; k++) m_h[k] = 1;
      errq.delete();
    end else if (en) begin
      rd = rx ^ ((m_type < 8) ? m_inv : 1'b0);
      e  = m_exp();
      er = rd ^ e;
      if (m_type < 8) begin
        for (int k = 31; k >= 2; k--) m_h[k] = m_h[k-1];
        m_h[1] = m_sync ? e : rd;
      end else begin
        m_ph = (m_ph + 1 + ((er && !m_sync) ? 1 : 0)) % 8;
      end
      if (!m_sync) begin
        m_lost = 0; m_berr = 0;
        if (er) m_run = 0;
        else begin
          m_run++;
          if (m_run == ((m_type < 8) ? 2 * b_len(m_type) : 20)) begin
            m_sync = 1; m_run = 0;
          end
        end
      end else begin
        errq.push_back(er);
        d = 0;
        if (errq.size() > 128) d = errq.pop_front();
        s = 0;
        foreach (errq[k]) s += int'(errq[k]);
        if (s > 25) begin
          m_sync = 0; m_lost = 1; m_berr = 0; errq.delete();
        end else begin
          m_lost = 0; m_berr = d;
        end
      end
    end
  endtask

  task automatic cyc(input bit rx, input bit en, input bit ld);
    rx_bit_i = rx; en_i = en; cfg_load_i = ld;
    @(posedge clk);
    model_step(rx, en, ld);
    @(negedge clk);
    cfg_load_i = 1'b0;
    chk(sync_o == m_sync, "R4 R5 R6 sync_o", int'(sync_o), int'(m_sync));
    chk(sync_lost_o == m_lost, "R7 sync_lost_o", int'(sync_lost_o), int'(m_lost));
    chk(bit_err_o == m_berr, "R8 bit_err_o", int'(bit_err_o), int'(m_berr));
    chk(clk_err_o == 1'b0, "R9 clk_err_o", int'(clk_err_o), 0);
    if (en || ld) begin
      if (sync_lost_o) lost_cnt++;
      if (bit_err_o) berr_cnt++;
    end
  endtask

  function automatic bit next_tx();
    bit b;
    if (s_type < 8) begin
      b = g_h[b_tap(s_type)] ^ g_h[b_len(s_type)];
      for (int k = 31; k >= 2; k--) g_h[k] = g_h[k-1];
      g_h[1] = b;
    end else begin
      b = bit'((b_word(s_type) >> (7 - (g_pos % 8))) & 1);
      g_pos++;
    end
    return b;
  endfunction

  task automatic send(input int n, input int every, input int nflip, input bit txinv, input bit gaps);
    int flips = 0;
    for (int i = 0; i < n; i++) begin
      bit b;
      b = next_tx();
      if (every > 0 && (i % every) == every - 1 && flips < nflip) begin
        b = ~b; flips++;
      end
      if (gaps && (i % 3) == 1) cyc(1'b0, 1'b0, 1'b0);
      cyc(b ^ txinv, 1'b1, 1'b0);
    end
  endtask

  task automatic load(input int t, input bit iv);
    cfg_type_i = 4'(t); cfg_inv_i = iv; s_type = t;
    cyc(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= 31; k++) begin
      m_h[k] = 1;
      g_h[k] = bit'((32'h2468ACE1 >> k) & 1);
    end
    repeat (3) @(negedge clk);
    chk(!sync_o && !sync_lost_o && !bit_err_o && !clk_err_o, "R10 reset outputs low",
        int'({sync_o, sync_lost_o, bit_err_o, clk_err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4: self-seeding lock in mode 0
    load(0, 0);
    send(150, 0, 0, 0, 0);
    chk(sync_o == 1'b1, "R4 lock on 9-bit sequence", int'(sync_o), 1);

    // R8: isolated errors reported 128 bits later
    berr_cnt = 0; lost_cnt = 0;
    send(400, 40, 3, 0, 0);
    chk(berr_cnt == 3, "R8 delayed error pulses", berr_cnt, 3);
    chk(lost_cnt == 0, "R7 no loss on sparse errors", lost_cnt, 0);

    // R6: exactly 25 errors keep lock
    berr_cnt = 0;
    send(100, 4, 25, 0, 0);
    chk(sync_o == 1'b1, "R6 lock held at 25 errors", int'(sync_o), 1);
    send(200, 0, 0, 0, 0);
    chk(berr_cnt == 25, "R8 all 25 reported", berr_cnt, 25);

    // R6 R7 R8: 26th error drops lock, pending reports discarded
    berr_cnt = 0; lost_cnt = 0;
    send(120, 4, 26, 0, 0);
    chk(lost_cnt == 1, "R7 single loss pulse", lost_cnt, 1);
    send(300, 0, 0, 0, 0);
    chk(berr_cnt == 0, "R8 burst errors discarded", berr_cnt, 0);
    chk(sync_o == 1'b1, "R4 relock after loss", int'(sync_o), 1);

    // R10: enable gaps
    berr_cnt = 0;
    send(300, 50, 2, 0, 1);
    chk(berr_cnt == 2, "R10 errors across enable gaps", berr_cnt, 2);

    // R2: reload while locked
    lost_cnt = 0;
    load(7, 1);
    chk(sync_o == 1'b0 && sync_lost_o == 1'b0, "R2 reload clears lock quietly",
        int'({sync_o, sync_lost_o}), 0);
    send(200, 0, 0, 1, 0);
    chk(sync_o == 1'b1, "R3 lock on inverted 31-bit sequence", int'(sync_o), 1);
    chk(lost_cnt == 0, "R2 no loss pulse from reload", lost_cnt, 0);

    // R3: wrong polarity never locks
    load(3, 1);
    send(200, 0, 0, 0, 0);
    chk(sync_o == 1'b0, "R3 polarity mismatch stays unlocked", int'(sync_o), 0);

    // R1: second 20-bit sequence
    load(4, 0);
    send(150, 0, 0, 0, 0);
    chk(sync_o == 1'b1, "R1 lock on code 4", int'(sync_o), 1);

    // R5: word modes at odd offsets, invert ignored
    load(10, 1); g_pos = 1;
    send(150, 0, 0, 0, 0);
    chk(sync_o == 1'b1, "R5 R3 word 55 locks, invert ignored", int'(sync_o), 1);
    load(14, 0); g_pos = 3;
    send(150, 0, 0, 0, 0);
    chk(sync_o == 1'b1, "R5 word 77 locks", int'(sync_o), 1);
    load(13, 0); g_pos = 5;
    send(150, 0, 0, 0, 0);
    chk(sync_o == 1'b1, "R5 word 80 locks", int'(sync_o), 1);
    berr_cnt = 0;
    send(300, 30, 2, 0, 0);
    chk(berr_cnt == 2, "R8 errors in word mode", berr_cnt, 2);
    chk(clk_err_o == 1'b0, "R9 slip flag low", int'(clk_err_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule